// File: doc/BRIEF.md
# Conditional Block State Sequencer

This block follows the "if-then" prefix of a compact 16-bit instruction stream. When a valid prefix word is decoded, an 8-bit state register is loaded with a 4-bit base condition and a 4-bit then/else pattern. That state makes up to four later instructions conditional. For the instruction now at the head of the block, the sequencer reports whether a conditional block is active, which 4-bit condition applies, and whether this is the block's final instruction. Each retire strobe moves the state on to the next instruction.

Some prefix forms are illegal: a reserved base condition, an "always" base condition with more than one then/else slot, or a prefix that arrives while a block is already active. A two-bit mode input picks how these are handled. The sequencer can raise an undefined-instruction pulse, treat the prefix as a no-op, or accept the prefix and load it. A restore port writes a whole saved state in one cycle, for example on return from an exception. Testing the condition against the flags is left to the surrounding pipeline.

Top module: `cond_block_seq`

## Requirements
- R1: A prefix is recognised only when `instrValid` is high, `instrWord[15:8]` equals 8'b10111111 and `instrWord[3:0]` is non-zero. Any other word, including one with a zero low nibble, leaves the state and flags unchanged.
- R2: A legal prefix loads the state as {`instrWord[7:4]`, `instrWord[3:0]`}, visible from the cycle after the decode edge. `curCond` is state[7:4]. `inBlock` is high while state[3:0] is non-zero. `blockLast` is high when state[3:0] equals 4'b1000.
- R3: The first conditional instruction uses the base condition. Each mask bit above the lowest set bit gives one further instruction, from bit 3 downward. A bit equal to base bit 0 means "then": the base condition is reused. The opposite value means "else": the base condition with bit 0 inverted.
- R4: Block length follows the lowest set mask bit: bit 3 gives 1 instruction, bit 2 gives 2, bit 1 gives 3 and bit 0 gives 4. After the retire strobe of the last instruction the state is 8'h00.
- R5: A retire strobe (`advance`) outside a block has no effect. So does a prefix word presented without `instrValid`.
- R6: These forms are illegal: base condition 4'b1111, or base condition 4'b1110 with more than one mask bit set. With `illegalMode` 2'b00, an illegal prefix raises `undefFlag` for exactly one cycle and leaves the state unchanged.
- R7: With `illegalMode` 2'b01, an illegal prefix raises `nopFlag` for one cycle and leaves the state unchanged. `undefFlag` and `nopFlag` are never high together.
- R8: With `illegalMode` 2'b10, an illegal prefix is loaded like a legal one, except that base condition 4'b1111 is stored as 4'b1110. `illegalMode` 2'b11 behaves as 2'b00.
- R9: A prefix decoded while `inBlock` is high is illegal and is handled by the same modes. Under 2'b10 it replaces the active block.
- R10: `restoreValid` loads `restoreState` in one cycle and takes priority over a same-cycle prefix and advance. A restored value whose low nibble is zero is stored as 8'h00.
- R11: While `rstN` is low the state is 8'h00 and both flags are low.
- R12: A prefix and an advance in the same cycle: the prefix is acted on and the advance is dropped, because the prefix itself never advances the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word strobe |
| instrWord | input | 16 | Instruction word being decoded |
| advance | input | 1 | Retire strobe of a conditional instruction |
| restoreValid | input | 1 | Load saved state |
| restoreState | input | 8 | Saved state value |
| illegalMode | input | 2 | Handling of illegal prefixes (0 undef, 1 nop, 2 accept, 3 undef) |
| inBlock | output | 1 | A conditional block is active |
| curCond | output | 4 | Condition for the current instruction |
| blockLast | output | 1 | Current instruction is the last of the block |
| undefFlag | output | 1 | One-cycle undefined-instruction pulse |
| nopFlag | output | 1 | One-cycle no-op pulse |

## Verification
The assertions assume that `restoreValid`, `instrValid` and `advance` are settled before each rising edge. They also assume that a retire strobe reaches the block only when the surrounding pipeline has an instruction to retire. The expected-state properties are guarded so that they apply only when no restore or prefix shares the cycle. The stimulus changes inputs only on falling edges and samples one full cycle after each action. It deliberately combines restore, prefix and advance in single cycles to reach the priority rules under those guards.

// File: rtl/condseq_pkg.sv
package condseq_pkg;
  localparam int COND_W  = 4;
  localparam int MASK_W  = 4;
  localparam int STATE_W = COND_W + MASK_W;
  localparam int INSTR_W = 16;
  localparam int OP_W    = INSTR_W - STATE_W;

  localparam logic [OP_W-1:0]   PREFIX_OP   = 8'b1011_1111;
  localparam logic [COND_W-1:0] COND_ALWAYS = 4'b1110;
  localparam logic [COND_W-1:0] COND_RSVD   = 4'b1111;

  typedef enum logic [1:0] {
    ILL_UNDEF = 2'b00,
    ILL_NOP   = 2'b01,
    ILL_ACCEPT = 2'b10,
    ILL_UNDEF2 = 2'b11
  } illMode_e;

  typedef struct packed {
    logic               loadState;
    logic [STATE_W-1:0] loadValue;
    logic               doAdvance;
    logic               raiseUndef;
    logic               raiseNop;
  } seqCtrl_t;
endpackage

// File: rtl/condseq_ctrl.sv
module condseq_ctrl
  import condseq_pkg::*;
(
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               advance,
  input  logic               restoreValid,
  input  logic [STATE_W-1:0] restoreState,
  input  logic [1:0]         illegalMode,
  input  logic               inBlock,
  output seqCtrl_t           ctrl
);
  logic [COND_W-1:0] firstCond;
  logic [MASK_W-1:0] thenMask;
  logic              isPrefix;
  logic              badCond;
  logic              isIllegal;
  logic [COND_W-1:0] fixedCond;
  illMode_e          mode;

  assign firstCond = instrWord[MASK_W +: COND_W];
  assign thenMask  = instrWord[MASK_W-1:0];
  assign isPrefix  = instrValid && (instrWord[INSTR_W-1 -: OP_W] == PREFIX_OP)
                     && (thenMask != '0);
  assign badCond   = (firstCond == COND_RSVD) ||
                     ((firstCond == COND_ALWAYS) && ($countones(thenMask) != 1));
  assign isIllegal = badCond || inBlock;
  assign fixedCond = (firstCond == COND_RSVD) ? COND_ALWAYS : firstCond;
  assign mode      = illMode_e'(illegalMode);

  always_comb begin
    ctrl = '0;
    if (restoreValid) begin
      ctrl.loadState = 1'b1;
      ctrl.loadValue = (restoreState[MASK_W-1:0] == '0) ? '0 : restoreState;
    end else if (isPrefix) begin
      if (!isIllegal || mode == ILL_ACCEPT) begin
        ctrl.loadState = 1'b1;
        ctrl.loadValue = {fixedCond, thenMask};
      end else if (mode == ILL_NOP) begin
        ctrl.raiseNop = 1'b1;
      end else begin
        ctrl.raiseUndef = 1'b1;
      end
    end else if (advance && inBlock) begin
      ctrl.doAdvance = 1'b1;
    end
  end

  // R7: strobes to the datapath are mutually exclusive
  always_comb begin
    assert_strobes_exclusive_R7: assert ($onehot0({ctrl.loadState, ctrl.doAdvance,
                                                   ctrl.raiseUndef, ctrl.raiseNop}));
  end
endmodule

// File: rtl/condseq_state.sv
module condseq_state
  import condseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  seqCtrl_t           ctrl,
  output logic [STATE_W-1:0] stateQ,
  output logic               undefQ,
  output logic               nopQ
);
  logic [STATE_W-1:0] shifted;
  logic [STATE_W-1:0] stateD;

  // upper condition bits stay, the lower five move one place up
  assign shifted = {stateQ[STATE_W-1 -: COND_W-1], stateQ[MASK_W-1:0], 1'b0};

  always_comb begin
    stateD = stateQ;
    if (ctrl.loadState) begin
      stateD = ctrl.loadValue;
    end else if (ctrl.doAdvance) begin
      stateD = (shifted[MASK_W-1:0] == '0) ? '0 : shifted;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= '0;
      undefQ <= 1'b0;
      nopQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      undefQ <= ctrl.raiseUndef;
      nopQ   <= ctrl.raiseNop;
    end
  end

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(undefQ && nopQ));

  assert_empty_is_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ[MASK_W-1:0] == '0) |-> (stateQ == '0));

  assert_advance_holds_base_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doAdvance |=> ((stateQ[STATE_W-1 -: COND_W-1] == $past(stateQ[STATE_W-1 -: COND_W-1]))
                        || (stateQ == '0)));

  assert_flag_keeps_state_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.raiseUndef || ctrl.raiseNop) |=> (stateQ == $past(stateQ)));
endmodule

// File: rtl/cond_block_seq.sv
module cond_block_seq
  import condseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         instrValid,
  input  logic [15:0]  instrWord,
  input  logic         advance,
  input  logic         restoreValid,
  input  logic [7:0]   restoreState,
  input  logic [1:0]   illegalMode,
  output logic         inBlock,
  output logic [3:0]   curCond,
  output logic         blockLast,
  output logic         undefFlag,
  output logic         nopFlag
);
  seqCtrl_t           ctrl;
  logic [STATE_W-1:0] stateQ;

  condseq_ctrl u_ctrl (
    .instrValid  (instrValid),
    .instrWord   (instrWord),
    .advance     (advance),
    .restoreValid(restoreValid),
    .restoreState(restoreState),
    .illegalMode (illegalMode),
    .inBlock     (inBlock),
    .ctrl        (ctrl)
  );

  condseq_state u_state (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .stateQ(stateQ),
    .undefQ(undefFlag),
    .nopQ  (nopFlag)
  );

  assign curCond   = stateQ[STATE_W-1 -: COND_W];
  assign inBlock   = (stateQ[MASK_W-1:0] != '0);
  assign blockLast = (stateQ[MASK_W-1:0] == {1'b1, {(MASK_W-1){1'b0}}});

  // port-level view of the prefix for the checks below
  logic portPrefix;
  logic portLegal;
  assign portPrefix = instrValid && (instrWord[15:8] == 8'hBF) && (instrWord[3:0] != 4'h0);
  assign portLegal  = (instrWord[7:4] != 4'hF) &&
                      !((instrWord[7:4] == 4'hE) && ($countones(instrWord[3:0]) != 1));

  assert_legal_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (portPrefix && portLegal && !inBlock && !restoreValid)
      |=> (inBlock && curCond == $past(instrWord[7:4])));

  assert_undef_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    (portPrefix && !portLegal && illegalMode == 2'b00 && !restoreValid)
      |=> (undefFlag && curCond == $past(curCond)));

  assert_last_ends_R4: assert property (@(posedge clk) disable iff (!rstN)
    (blockLast && advance && !restoreValid && !portPrefix) |=> !inBlock);

  assert_restore_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (restoreValid && restoreState[3:0] != 4'h0)
      |=> (curCond == $past(restoreState[7:4]) && inBlock));

  assert_idle_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!inBlock && !restoreValid && !portPrefix) |=> !inBlock);
endmodule

// File: tb/cond_block_seq_tb.sv
`timescale 1ns/1ps
module cond_block_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = 16'h0000;
  logic        advance = 1'b0;
  logic        restoreValid = 1'b0;
  logic [7:0]  restoreState = 8'h00;
  logic [1:0]  illegalMode = 2'b00;
  logic        inBlock, blockLast, undefFlag, nopFlag;
  logic [3:0]  curCond;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cond_block_seq u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .advance(advance), .restoreValid(restoreValid), .restoreState(restoreState),
    .illegalMode(illegalMode), .inBlock(inBlock), .curCond(curCond),
    .blockLast(blockLast), .undefFlag(undefFlag), .nopFlag(nopFlag)
  );

  // {instr[15:0], length[2:0], cond0..cond3 (cond0 in the top nibble)}
  localparam int NVEC = 6;
  localparam logic [34:0] VEC [NVEC] = '{
    {16'hBF08, 3'd1, 16'h0000},
    {16'hBF04, 3'd2, 16'h0000},
    {16'hBF13, 3'd4, 16'h1001},
    {16'hBFA6, 3'd3, 16'hAAB0},
    {16'hBFB9, 3'd4, 16'hBBAA},
    {16'hBFE8, 3'd1, 16'hE000}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [15:0] w);
    instrValid = 1'b1; instrWord = w; step(); instrValid = 1'b0;
  endtask

  task automatic adv();
    advance = 1'b1; step(); advance = 1'b0;
  endtask

  task automatic expectState(input string req, input logic ib, input logic [3:0] c,
                             input logic last);
    check(inBlock == ib, req, {31'd0, inBlock}, {31'd0, ib});
    check(curCond == c, req, {28'd0, curCond}, {28'd0, c});
    check(blockLast == last, req, {31'd0, blockLast}, {31'd0, last});
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    step(); step();
    // R11 reset state
    expectState("R11", 1'b0, 4'h0, 1'b0);
    check(!undefFlag && !nopFlag, "R11", {30'd0, undefFlag, nopFlag}, 32'd0);
    rstN = 1'b1;
    step();

    // vector table: R2 R3 R4
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] w;
      logic [2:0]  len;
      logic [15:0] cs;
      w = VEC[v][34:19]; len = VEC[v][18:16]; cs = VEC[v][15:0];
      issue(w);
      for (int k = 0; k < int'(len); k++) begin
        expectState("R3", 1'b1, cs[15-4*k -: 4], (k == int'(len) - 1));
        adv();
      end
      expectState("R4", 1'b0, 4'h0, 1'b0);
    end

    // R1 zero mask and wrong opcode ignored
    issue(16'hBF00); expectState("R1", 1'b0, 4'h0, 1'b0);
    issue(16'hBE08); expectState("R1", 1'b0, 4'h0, 1'b0);
    // R5 word without strobe, advance outside block
    instrWord = 16'hBF08; step(); expectState("R5", 1'b0, 4'h0, 1'b0);
    adv(); expectState("R5", 1'b0, 4'h0, 1'b0);

    // R6 undef mode
    illegalMode = 2'b00; issue(16'hBFF8);
    check(undefFlag && !nopFlag, "R6", {30'd0, undefFlag, nopFlag}, 32'd2);
    expectState("R6", 1'b0, 4'h0, 1'b0);
    step(); check(!undefFlag, "R6", {31'd0, undefFlag}, 32'd0);
    issue(16'hBFEC);
    check(undefFlag, "R6", {31'd0, undefFlag}, 32'd1);
    issue(16'hBFE4); expectState("R6", 1'b1, 4'hE, 1'b0);
    adv(); adv(); expectState("R6", 1'b0, 4'h0, 1'b0);

    // R7 nop mode
    illegalMode = 2'b01; issue(16'hBFF8);
    check(nopFlag && !undefFlag, "R7", {30'd0, undefFlag, nopFlag}, 32'd1);
    expectState("R7", 1'b0, 4'h0, 1'b0);

    // R8 accept mode and mode 3
    illegalMode = 2'b10; issue(16'hBFF8);
    expectState("R8", 1'b1, 4'hE, 1'b1);
    check(!undefFlag && !nopFlag, "R8", {30'd0, undefFlag, nopFlag}, 32'd0);
    adv(); expectState("R8", 1'b0, 4'h0, 1'b0);
    issue(16'hBFEC); expectState("R8", 1'b1, 4'hE, 1'b0);
    adv(); expectState("R8", 1'b1, 4'hF, 1'b1);
    adv(); expectState("R8", 1'b0, 4'h0, 1'b0);
    illegalMode = 2'b11; issue(16'hBFF8);
    check(undefFlag, "R8", {31'd0, undefFlag}, 32'd1);
    expectState("R8", 1'b0, 4'h0, 1'b0);

    // R9 nested prefix
    illegalMode = 2'b01; issue(16'hBF04); issue(16'hBF18);
    check(nopFlag, "R9", {31'd0, nopFlag}, 32'd1);
    expectState("R9", 1'b1, 4'h0, 1'b0);
    illegalMode = 2'b00; issue(16'hBF18);
    check(undefFlag, "R9", {31'd0, undefFlag}, 32'd1);
    expectState("R9", 1'b1, 4'h0, 1'b0);
    illegalMode = 2'b10; issue(16'hBF18);
    expectState("R9", 1'b1, 4'h1, 1'b1);
    adv(); expectState("R9", 1'b0, 4'h0, 1'b0);

    // R10 restore priority
    restoreValid = 1'b1; restoreState = 8'h35; advance = 1'b1; step();
    restoreValid = 1'b0; advance = 1'b0;
    expectState("R10", 1'b1, 4'h3, 1'b0);
    restoreValid = 1'b1; restoreState = 8'h28; instrValid = 1'b1; instrWord = 16'hBF18; step();
    restoreValid = 1'b0; instrValid = 1'b0;
    expectState("R10", 1'b1, 4'h2, 1'b1);
    restoreValid = 1'b1; restoreState = 8'h70; step(); restoreValid = 1'b0;
    expectState("R10", 1'b0, 4'h0, 1'b0);

    // R12 prefix beats same-cycle advance
    illegalMode = 2'b00;
    advance = 1'b1; issue(16'hBF08); advance = 1'b0;
    expectState("R12", 1'b1, 4'h0, 1'b1);
    illegalMode = 2'b10;
    advance = 1'b1; issue(16'hBF14); advance = 1'b0;
    expectState("R12", 1'b1, 4'h1, 1'b0);
    adv(); adv(); expectState("R12", 1'b0, 4'h0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule